// File: doc/BRIEF.md
# Single-Phase Grid Synchronisation PLL Core

This block tracks the fundamental of a single-phase grid voltage sampled at 10 kHz. On every sample strobe it takes one signed sample, forms the error between that sample and its own reconstructed fundamental y = A·sin(θ), and uses that error to drive three coupled state updates. An integrator corrects the amplitude estimate A. A proportional-integral controller corrects the frequency word. A wrapping phase accumulator advances θ by the frequency word. Sine and cosine come from one quarter-wave polynomial generator; the cosine is the sine taken a quarter turn ahead.

The two error products, e·sin(θ) for the amplitude path and e·cos(θ) for the frequency path, leave the block on output ports. They come back through a moving-window ripple filter that sits outside this block, and the filtered values enter the integrator and the PI controller. The path from the product outputs to the filtered inputs may be combinational. When the filter is bypassed by a direct wire, the block acts as a plain in-loop tracker.

The frequency estimate is exported as a phase-increment word, so that neighbouring blocks can size their delay lines and windows to the measured grid period.

Top module: `grid_pll`

## Requirements
- R1: A synchronous reset sets the amplitude state, the frequency integral and the phase to zero, and sets the frequency word to NOM = floor(50·2^32/10000) = 21474836. After reset, amp_o, fund_o and phase_o read 0 and freq_o reads NOM.
- R2: While smp_en is low, amp_o, phase_o and freq_o hold their values, whatever smp_i and the filtered inputs do.
- R3: On each strobe, phase_o advances modulo 2^32 by the freq_o value that was present before that strobe.
- R4: Samples, amplitude and fund_o are Q14 signed, so 16384 is 1.0. The error e = smp_i − fund_o. The error products are amp_err_o = e·sin(θ) and frq_err_o = e·cos(θ), each Q28. At phase 0, sin is 0 and cos is 16384.
- R5: On each strobe, a Q30 amplitude accumulator adds (amp_flt_i·KA_Q)>>>22, where KA_Q = round(130/10000·2^24). amp_o is the accumulator shifted right arithmetically by 16.
- R6: The amplitude accumulator saturates at 2^31−1 and −2^31, so amp_o pins at 32767 or −32768 and does not wrap. Its next step starts from the bound.
- R7: With S = 2^32/(2π·10000), KP_Q = round(130·S/16) and KI_Q = round(3000·S/10000/16). On each strobe, a Q16 integral adds (frq_flt_i·KI_Q)>>>8. freq_o becomes NOM + ((frq_flt_i·KP_Q)>>>24) + (integral>>>16).
- R8: The integral saturates at ±SPAN·2^16, and freq_o is clamped to NOM±SPAN, where SPAN = floor(20·2^32/10000) = 8589934.
- R9: With the filter bypassed and a clean 0.8 pu sinusoid at 50 Hz or 52 Hz, the loop locks within 0.6 s. After lock, amp_o is within 3 % of the input amplitude and freq_o is within 0.5 Hz of the input frequency. The phase is within 3 degrees of the input phase, and fund_o is within 4 % of full amplitude of the input fundamental.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample strobe; one state update per high cycle |
| smp_i | input | 16 | Signed Q14 input sample |
| amp_err_o | output | 33 | Signed Q28 product e·sin(θ) toward the ripple filter |
| frq_err_o | output | 33 | Signed Q28 product e·cos(θ) toward the ripple filter |
| amp_flt_i | input | 33 | Filtered amplitude-path product |
| frq_flt_i | input | 33 | Filtered frequency-path product |
| amp_o | output | 16 | Signed Q14 amplitude estimate |
| fund_o | output | 16 | Signed Q14 reconstructed fundamental |
| phase_o | output | 32 | Phase, full turn = 2^32 |
| freq_o | output | 32 | Frequency as phase increment per sample |

## Verification
The proportional path and the integral saturation can act in the same strobe. Both feed the frequency clamp, so one strobe can push the integral onto its bound while the proportional term alone already exceeds the clamp window. The bench drives a large negative filtered frequency product for many strobes, well past the point where the integral bound is reached. It then releases the input to zero for one strobe and applies a small positive input for one more. The block is judged correct only if freq_o first reads exactly NOM−SPAN, and then exactly NOM−SPAN plus one proportional and one integral step. That shows the integral sat at its bound and did not wrap.

// File: rtl/grid_pll.sv
module grid_pll #(
  parameter int DW      = 16,
  parameter int PW      = 32,
  parameter int FS_HZ   = 10000,
  parameter int NOM_HZ  = 50,
  parameter int SPAN_HZ = 20,
  parameter int KA      = 130,
  parameter int KP      = 130,
  parameter int KI      = 3000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  smp_en,
  input  logic signed [DW-1:0]  smp_i,
  output logic signed [2*DW:0]  amp_err_o,
  output logic signed [2*DW:0]  frq_err_o,
  input  logic signed [2*DW:0]  amp_flt_i,
  input  logic signed [2*DW:0]  frq_flt_i,
  output logic signed [DW-1:0]  amp_o,
  output logic signed [DW-1:0]  fund_o,
  output logic [PW-1:0]         phase_o,
  output logic [PW-1:0]         freq_o
);

  localparam int     EW   = 2*DW + 1;
  localparam int     AW   = DW + 16;
  localparam int     FW   = PW + 18;
  localparam int     SW   = EW + 34;
  localparam real    STEP = (2.0**PW) / (6.283185307179586 * FS_HZ);
  localparam int     KA_Q = $rtoi(real'(KA) / FS_HZ * (2.0**24) + 0.5);
  localparam int     KP_Q = $rtoi(KP * STEP / 16.0 + 0.5);
  localparam int     KI_Q = $rtoi(KI * STEP / FS_HZ / 16.0 + 0.5);
  localparam longint NOM  = (longint'(NOM_HZ) <<< PW) / FS_HZ;
  localparam longint SPAN = (longint'(SPAN_HZ) <<< PW) / FS_HZ;

  localparam logic signed [SW-1:0] A_HI = SW'((longint'(1) <<< (AW-1)) - 1);
  localparam logic signed [SW-1:0] A_LO = -A_HI - 1;
  localparam logic signed [SW-1:0] D_HI = SW'(SPAN * 65536);
  localparam logic signed [SW-1:0] D_LO = -D_HI;
  localparam logic signed [SW-1:0] F_HI = SW'(NOM + SPAN);
  localparam logic signed [SW-1:0] F_LO = SW'(NOM - SPAN);
  localparam logic [PW-1:0]        QTR  = {2'b01, {(PW-2){1'b0}}};

  function automatic logic signed [DW-1:0] qsin(input logic [PW-1:0] ph);
    logic [63:0] t, t2, t4, poly, s;
    logic signed [DW-1:0] m;
    t    = ph[PW-2] ? 64'd65536 - 64'(ph[PW-3 -: 16]) : 64'(ph[PW-3 -: 16]);
    t2   = (t * t) >> 16;
    t4   = (t2 * t2) >> 16;
    poly = 64'd102944 - ((64'd42048 * t2) >> 16) + ((64'd4640 * t4) >> 16);
    s    = (t * poly) >> (34 - DW);
    m    = DW'(s);
    return ph[PW-1] ? -m : m;
  endfunction

  logic signed [AW-1:0]   amp_acc, amp_nxt;
  logic signed [FW-1:0]   dw_acc, dw_nxt;
  logic [PW-1:0]          phase, freq_r, freq_nxt;
  logic signed [SW-1:0]   amp_sum, dw_sum, fr_sum;
  logic signed [EW+31:0]  ka_mul, kp_mul, ki_mul;
  logic signed [DW-1:0]   sin_w, cos_w;
  logic signed [2*DW-1:0] y_full;
  logic signed [DW:0]     err;

  assign sin_w     = qsin(phase);
  assign cos_w     = qsin(phase + QTR);
  assign amp_o     = DW'(amp_acc >>> 16);
  assign y_full    = amp_o * sin_w;
  assign fund_o    = DW'(y_full >>> (DW-2));
  assign err       = (DW+1)'(smp_i) - (DW+1)'(fund_o);
  assign amp_err_o = err * sin_w;
  assign frq_err_o = err * cos_w;
  assign phase_o   = phase;
  assign freq_o    = freq_r;

  assign ka_mul = amp_flt_i * $signed(32'(KA_Q));
  assign kp_mul = frq_flt_i * $signed(32'(KP_Q));
  assign ki_mul = frq_flt_i * $signed(32'(KI_Q));

  always_comb begin
    amp_sum = SW'(amp_acc) + SW'(ka_mul >>> 22);
    if (amp_sum > A_HI)      amp_nxt = AW'(A_HI);
    else if (amp_sum < A_LO) amp_nxt = AW'(A_LO);
    else                     amp_nxt = AW'(amp_sum);

    dw_sum = SW'(dw_acc) + SW'(ki_mul >>> 8);
    if (dw_sum > D_HI)       dw_nxt = FW'(D_HI);
    else if (dw_sum < D_LO)  dw_nxt = FW'(D_LO);
    else                     dw_nxt = FW'(dw_sum);

    fr_sum = SW'(NOM) + SW'(kp_mul >>> 24) + SW'(dw_nxt >>> 16);
    if (fr_sum > F_HI)       freq_nxt = PW'(F_HI);
    else if (fr_sum < F_LO)  freq_nxt = PW'(F_LO);
    else                     freq_nxt = PW'(fr_sum);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      amp_acc <= '0;
      dw_acc  <= '0;
      phase   <= '0;
      freq_r  <= PW'(NOM);
    end else if (smp_en) begin
      amp_acc <= amp_nxt;
      dw_acc  <= dw_nxt;
      phase   <= phase + freq_r;
      freq_r  <= freq_nxt;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (amp_acc == '0 && dw_acc == '0 && phase == '0 && freq_r == PW'(NOM)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> ($stable(amp_acc) && $stable(dw_acc) && $stable(phase) && $stable(freq_r)));

  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    smp_en |=> (phase == $past(phase) + $past(freq_r)));

  // R6
  amp_up_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_en && !amp_flt_i[EW-1] && amp_flt_i != '0) |=> (amp_acc >= $past(amp_acc)));

  // R6
  amp_down_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_en && amp_flt_i[EW-1]) |=> (amp_acc <= $past(amp_acc)));

  // R8
  freq_window_chk: assert property (@(posedge clk) disable iff (rst)
    (freq_r >= PW'(NOM - SPAN) && freq_r <= PW'(NOM + SPAN)));

  // R8
  integ_down_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_en && frq_flt_i[EW-1]) |=> (dw_acc <= $past(dw_acc)));

endmodule

// File: tb/grid_pll_tb.sv
`timescale 1ns/1ps
module grid_pll_tb;
  localparam real    STEP = (2.0**32) / (6.283185307179586 * 10000.0);
  localparam int     KA_Q = $rtoi(130.0 / 10000.0 * (2.0**24) + 0.5);
  localparam int     KP_Q = $rtoi(130.0 * STEP / 16.0 + 0.5);
  localparam int     KI_Q = $rtoi(3000.0 * STEP / 10000.0 / 16.0 + 0.5);
  localparam longint NOM  = (longint'(50) <<< 32) / 10000;
  localparam longint SPAN = (longint'(20) <<< 32) / 10000;

  logic clk = 1'b0, rst = 1'b1, smp_en = 1'b0, loop = 1'b0;
  logic signed [15:0] smp = '0;
  logic signed [32:0] amp_err, frq_err, amp_flt, frq_flt;
  logic signed [32:0] amp_man = '0, frq_man = '0;
  logic signed [15:0] amp, fund;
  logic [31:0] phase, freq;
  int total = 0, bad = 0;
  longint aacc, dwm, fexp;
  real ph;

  always #5 clk = ~clk;

  assign amp_flt = loop ? amp_err : amp_man;
  assign frq_flt = loop ? frq_err : frq_man;

  grid_pll u_dut (
    .clk(clk), .rst(rst), .smp_en(smp_en), .smp_i(smp),
    .amp_err_o(amp_err), .frq_err_o(frq_err),
    .amp_flt_i(amp_flt), .frq_flt_i(frq_flt),
    .amp_o(amp), .fund_o(fund), .phase_o(phase), .freq_o(freq)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; smp_en = 1'b0; loop = 1'b0; amp_man = '0; frq_man = '0; smp = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    aacc = 0; dwm = 0; fexp = NOM;
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) smp_en = 1'b1;
      @(negedge clk) smp_en = 1'b0;
    end
  endtask

  task automatic astep(input longint f, input int n);
    amp_man = 33'(f);
    for (int i = 0; i < n; i++) begin
      aacc = aacc + ((f * KA_Q) >>> 22);
      if (aacc > 64'sd2147483647) aacc = 64'sd2147483647;
      if (aacc < -64'sd2147483648) aacc = -64'sd2147483648;
    end
    strobe(n);
  endtask

  task automatic fstep(input longint f, input int n);
    frq_man = 33'(f);
    for (int i = 0; i < n; i++) begin
      dwm = dwm + ((f * KI_Q) >>> 8);
      if (dwm > SPAN * 65536) dwm = SPAN * 65536;
      if (dwm < -SPAN * 65536) dwm = -SPAN * 65536;
      fexp = NOM + ((f * KP_Q) >>> 24) + (dwm >>> 16);
      if (fexp > NOM + SPAN) fexp = NOM + SPAN;
      if (fexp < NOM - SPAN) fexp = NOM - SPAN;
    end
    strobe(n);
  endtask

  task automatic t_reset();
    do_reset();
    chk(amp == 0, "R1 amp", longint'(amp), 0);
    chk(fund == 0, "R1 fund", longint'(fund), 0);
    chk(phase == 0, "R1 phase", longint'(phase), 0);
    chk(longint'(freq) == NOM, "R1 freq", longint'(freq), NOM);
  endtask

  task automatic t_products();
    do_reset();
    smp = 16'sd8192; #1;
    chk(longint'(frq_err) == 64'sd134217728, "R4 cos product", longint'(frq_err), 134217728);
    chk(amp_err == 0, "R4 sin product", longint'(amp_err), 0);
    smp = -16'sd16384; #1;
    chk(longint'(frq_err) == -64'sd268435456, "R4 negative product", longint'(frq_err), -268435456);
  endtask

  task automatic t_phase();
    longint e;
    do_reset();
    strobe(7);
    e = (7 * NOM) % (longint'(1) <<< 32);
    chk(longint'(phase) == e, "R3 phase 7", longint'(phase), e);
    chk(longint'(freq) == NOM, "R3 freq steady", longint'(freq), NOM);
    strobe(493);
    e = (500 * NOM) % (longint'(1) <<< 32);
    chk(longint'(phase) == e, "R3 phase wrap", longint'(phase), e);
  endtask

  task automatic t_amp();
    do_reset();
    astep(longint'(1) <<< 28, 100);
    chk(longint'(amp) == (aacc >>> 16), "R5 amp rise", longint'(amp), aacc >>> 16);
    astep(-(longint'(1) <<< 27), 40);
    chk(longint'(amp) == (aacc >>> 16), "R5 amp fall", longint'(amp), aacc >>> 16);
  endtask

  task automatic t_hold();
    logic [31:0] p0, f0;
    logic signed [15:0] a0;
    a0 = amp; p0 = phase; f0 = freq;
    smp = 16'sd12345; amp_man = 33'sd1073741824; frq_man = 33'sd1073741824;
    repeat (20) @(negedge clk);
    chk(amp == a0, "R2 amp held", longint'(amp), longint'(a0));
    chk(phase == p0, "R2 phase held", longint'(phase), longint'(p0));
    chk(freq == f0, "R2 freq held", longint'(freq), longint'(f0));
  endtask

  task automatic t_amp_sat();
    do_reset();
    astep(longint'(1) <<< 31, 40);
    chk(amp == 16'sd32767, "R6 amp top", longint'(amp), 32767);
    astep(-(longint'(1) <<< 31), 60);
    chk(amp == -16'sd32768, "R6 amp bottom", longint'(amp), -32768);
    astep(longint'(1) <<< 28, 1);
    chk(longint'(amp) == (aacc >>> 16), "R6 step from bound", longint'(amp), aacc >>> 16);
  endtask

  task automatic t_freq();
    do_reset();
    fstep(longint'(1) <<< 24, 1);
    chk(longint'(freq) == fexp, "R7 first step", longint'(freq), fexp);
    fstep(longint'(1) <<< 24, 1);
    chk(longint'(freq) == fexp, "R7 second step", longint'(freq), fexp);
    fstep(0, 1);
    chk(longint'(freq) == fexp, "R7 integral kept", longint'(freq), fexp);
  endtask

  task automatic t_freq_sat();
    longint e;
    do_reset();
    fstep(-(longint'(1) <<< 31), 1);
    chk(longint'(freq) == NOM - SPAN, "R8 low clamp", longint'(freq), NOM - SPAN);
    fstep(-(longint'(1) <<< 31), 80);
    fstep(0, 1);
    chk(longint'(freq) == NOM - SPAN, "R8 integral at bound", longint'(freq), NOM - SPAN);
    fstep(longint'(1) <<< 24, 1);
    e = NOM - SPAN + KP_Q + KI_Q;
    chk(longint'(freq) == e, "R8 leave bound", longint'(freq), e);
    chk(fexp == e, "R8 model agrees", fexp, e);
    fstep(longint'(1) <<< 31, 120);
    chk(longint'(freq) == NOM + SPAN, "R8 high clamp", longint'(freq), NOM + SPAN);
  endtask

  task automatic run_lock(input real fhz, input int n, input string tag);
    real uamp, s, dp, fin;
    longint einc;
    uamp = 13107.0;
    loop = 1'b1;
    for (int i = 0; i < n; i++) begin
      s = uamp * $sin(6.283185307179586 * ph);
      smp = 16'($rtoi(s >= 0.0 ? s + 0.5 : s - 0.5));
      @(negedge clk) smp_en = 1'b1;
      @(negedge clk) smp_en = 1'b0;
      ph = ph + fhz / 10000.0;
      if (ph >= 1.0) ph = ph - 1.0;
    end
    einc = longint'($rtoi(fhz * (2.0**32) / 10000.0));
    chk(longint'(freq) > einc - 214748 && longint'(freq) < einc + 214748,
        {tag, " R9 freq"}, longint'(freq), einc);
    chk(longint'(amp) > 12714 && longint'(amp) < 13500, {tag, " R9 amp"}, longint'(amp), 13107);
    dp = real'(phase) / (2.0**32) - ph;
    if (dp > 0.5) dp = dp - 1.0;
    if (dp < -0.5) dp = dp + 1.0;
    chk(dp < 0.00834 && dp > -0.00834, {tag, " R9 phase"}, longint'($rtoi(dp * 360000.0)), 0);
    fin = uamp * $sin(6.283185307179586 * ph);
    chk(real'(fund) - fin < 524.0 && fin - real'(fund) < 524.0, {tag, " R9 fundamental"},
        longint'(fund), longint'($rtoi(fin)));
  endtask

  initial begin
    #1_500_000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    ph = 0.0;
    t_reset();
    t_products();
    t_phase();
    t_amp();
    t_hold();
    t_amp_sat();
    t_freq();
    t_freq_sat();
    do_reset();
    ph = 0.0;
    run_lock(50.0, 6000, "50Hz");
    run_lock(52.0, 6000, "52Hz");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule